// File: doc/BRIEF.md
# Sixteen-bit instruction control decoder

This block turns a 16-bit instruction word into the fields and control strobes that a small 8-bit datapath needs to execute it. The opcode always sits in the top four bits. The register indices, the signed 9-bit immediate and the 12-bit jump target are all sliced out of the same word in parallel. The consumer picks whichever fields its format uses.

The control half maps the opcode to seven datapath controls: a register-write enable, memory read and write strobes, an operand-source select, branch and jump requests, and a 2-bit ALU function. Arithmetic, compare and move all write a register through the ALU path. Loads and stores force the immediate operand. Branch and jump each raise only their own request. Every other code decodes to a bubble, including the four codes held back for bitwise operations. The decoder has no state, so its outputs settle within the cycle in which the word arrives.

Top module: `idec_top`

## Requirements
- R1: `opcode_o` equals `instr_i[15:12]` for every instruction word.
- R2: `rd_o`, `rs_o` and `rt_o` equal `instr_i[11:9]`, `instr_i[8:6]` and `instr_i[5:3]`, whatever the opcode.
- R3: `imm_o[8:0]` equals `instr_i[8:0]`, and every bit of `imm_o[15:9]` equals `instr_i[8]`.
- R4: `jmp_addr_o` equals `instr_i[11:0]`.
- R5: Opcodes 0x1 (add), 0x2 (subtract), 0x3 (compare) and 0x4 (move) drive `reg_wr_o`=1 and `alu_imm_o`=0, and keep the memory, branch and jump strobes at 0. `alu_fn_o` is 2'b01 for 0x2 and 2'b00 for the other three. The function codes are 00 add, 01 subtract, 10 AND, 11 OR.
- R6: Opcode 0x5 (load) drives `mem_rd_o`, `alu_imm_o` and `reg_wr_o` to 1, drives every other strobe to 0, and sets `alu_fn_o`=00.
- R7: Opcode 0x6 (store) drives `mem_wr_o` and `alu_imm_o` to 1, drives every other strobe, including `reg_wr_o`, to 0, and sets `alu_fn_o`=00.
- R8: Opcode 0x7 drives only `branch_o`, and opcode 0x8 drives only `jump_o`. In both cases `alu_fn_o`=00.
- R9: Opcode 0x0, the reserved opcodes 0x9 to 0xC and the undefined opcodes 0xD to 0xF hold all six strobes at 0 and `alu_fn_o` at 00.
- R10: All outputs are a pure function of `instr_i` and follow it within the same cycle, with no registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| opcode_o | output | 4 | Opcode field |
| rd_o | output | 3 | Destination register index |
| rs_o | output | 3 | First source register index |
| rt_o | output | 3 | Second source register index |
| imm_o | output | 16 | Sign-extended 9-bit immediate |
| jmp_addr_o | output | 12 | Absolute jump target |
| reg_wr_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| alu_imm_o | output | 1 | ALU second operand from immediate |
| branch_o | output | 1 | Conditional branch request |
| jump_o | output | 1 | Unconditional jump request |
| alu_fn_o | output | 2 | ALU function code |

## Verification
The bench steps through all sixteen opcodes and places the immediate at its sign boundaries: 0x0FF, 0x100, 0x1FF and zero. A wrong extension bit shows up there as a positive offset read as negative, or the reverse. The store opcode is checked for a stray register write, and the reserved bitwise codes for any live strobe, because a decoder that aliased them onto arithmetic would corrupt registers. Random words with random upper bits look for leakage between fields and the opcode decode, such as a register index that changes with the opcode.

// File: rtl/idec_pkg.sv
package idec_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_CMP  = 4'h3,
    OP_MOV  = 4'h4,
    OP_LOAD = 4'h5,
    OP_STOR = 4'h6,
    OP_BRA  = 4'h7,
    OP_JMP  = 4'h8
  } opcode_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alu_fn_e;

  typedef struct packed {
    logic    reg_wr;
    logic    mem_rd;
    logic    mem_wr;
    logic    alu_imm;
    logic    branch;
    logic    jump;
    alu_fn_e alu_fn;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{default: '0, alu_fn: FN_ADD};
endpackage

// File: rtl/idec_fields.sv
module idec_fields #(
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4,
  parameter int REG_W   = 3,
  parameter int IMM_W   = 9,
  parameter int IMMX_W  = 16,
  parameter int JADR_W  = 12
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OPC_W-1:0]   opcode_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [REG_W-1:0]   rs_o,
  output logic [REG_W-1:0]   rt_o,
  output logic [IMMX_W-1:0]  imm_o,
  output logic [JADR_W-1:0]  jmp_addr_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RD_LSB  = OPC_LSB - REG_W;
  localparam int RS_LSB  = RD_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;

  assign opcode_o   = instr_i[INSTR_W-1:OPC_LSB];
  assign rd_o       = instr_i[RD_LSB +: REG_W];
  assign rs_o       = instr_i[RS_LSB +: REG_W];
  assign rt_o       = instr_i[RT_LSB +: REG_W];
  assign jmp_addr_o = instr_i[JADR_W-1:0];

  // copy the immediate, replicate its top bit upward
  for (genvar b = 0; b < IMMX_W; b++) begin : g_imm
    if (b < IMM_W) begin : g_low
      assign imm_o[b] = instr_i[b];
    end else begin : g_ext
      assign imm_o[b] = instr_i[IMM_W-1];
    end
  end

  // the register format leaves its lowest bits undefined
  logic unused_pad;
  assign unused_pad = ^instr_i[RT_LSB-1:0];
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = CTRL_IDLE;
    unique case (opcode_i)
      OP_ADD, OP_CMP, OP_MOV: ctrl_o.reg_wr = 1'b1;
      OP_SUB: begin
        ctrl_o.reg_wr = 1'b1;
        ctrl_o.alu_fn = FN_SUB;
      end
      OP_LOAD: begin
        ctrl_o.mem_rd  = 1'b1;
        ctrl_o.alu_imm = 1'b1;
        ctrl_o.reg_wr  = 1'b1;
      end
      OP_STOR: begin
        ctrl_o.mem_wr  = 1'b1;
        ctrl_o.alu_imm = 1'b1;
      end
      OP_BRA:  ctrl_o.branch = 1'b1;
      OP_JMP:  ctrl_o.jump   = 1'b1;
      default: ctrl_o = CTRL_IDLE; // nop, reserved bitwise, undefined
    endcase
  end
endmodule

// File: rtl/idec_top.sv
module idec_top
  import idec_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4,
  parameter int REG_W   = 3,
  parameter int IMM_W   = 9,
  parameter int IMMX_W  = 16,
  parameter int JADR_W  = 12
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OPC_W-1:0]   opcode_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [REG_W-1:0]   rs_o,
  output logic [REG_W-1:0]   rt_o,
  output logic [IMMX_W-1:0]  imm_o,
  output logic [JADR_W-1:0]  jmp_addr_o,
  output logic               reg_wr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               alu_imm_o,
  output logic               branch_o,
  output logic               jump_o,
  output logic [1:0]         alu_fn_o
);
  logic [OPC_W-1:0] opcode;
  ctrl_t            ctrl;

  idec_fields #(
    .INSTR_W(INSTR_W), .OPC_W(OPC_W), .REG_W(REG_W),
    .IMM_W(IMM_W), .IMMX_W(IMMX_W), .JADR_W(JADR_W)
  ) i_fields (
    .instr_i    (instr_i),
    .opcode_o   (opcode),
    .rd_o       (rd_o),
    .rs_o       (rs_o),
    .rt_o       (rt_o),
    .imm_o      (imm_o),
    .jmp_addr_o (jmp_addr_o)
  );

  idec_ctrl #(.OPC_W(OPC_W)) i_ctrl (
    .opcode_i (opcode),
    .ctrl_o   (ctrl)
  );

  assign opcode_o  = opcode;
  assign reg_wr_o  = ctrl.reg_wr;
  assign mem_rd_o  = ctrl.mem_rd;
  assign mem_wr_o  = ctrl.mem_wr;
  assign alu_imm_o = ctrl.alu_imm;
  assign branch_o  = ctrl.branch;
  assign jump_o    = ctrl.jump;
  assign alu_fn_o  = ctrl.alu_fn;
endmodule

// File: rtl/idec_checker.sv
module idec_checker (
  input logic [15:0] instr_i,
  input logic [15:0] imm_o,
  input logic [11:0] jmp_addr_o,
  input logic        reg_wr_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        alu_imm_o,
  input logic        branch_o,
  input logic        jump_o,
  input logic [1:0]  alu_fn_o
);
  logic [5:0] strb;
  assign strb = {reg_wr_o, mem_rd_o, mem_wr_o, alu_imm_o, branch_o, jump_o};

  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_imm_sign_r3: assert (imm_o == {{7{instr_i[8]}}, instr_i[8:0]});
      p_jmp_field_r4: assert (jmp_addr_o == instr_i[11:0]);
      // subtract function only ever on a register-writing op
      p_sub_writes_r5: assert (alu_fn_o != 2'b01 || (reg_wr_o && !alu_imm_o));
      p_load_excl_r6: assert (!mem_rd_o || (!mem_wr_o && reg_wr_o));
      p_store_nowr_r7: assert (!mem_wr_o || (!reg_wr_o && alu_imm_o));
      p_flow_alone_r8: assert (!(branch_o || jump_o) || $onehot(strb));
      p_reserved_idle_r9: assert (!(instr_i[15:12] == 4'h0 || instr_i[15:12] >= 4'h9)
                                  || (strb == '0 && alu_fn_o == 2'b00));
      p_fn_range_r10: assert (alu_fn_o[1] == 1'b0);
    end
  end
endmodule

bind idec_top idec_checker i_chk (
  .instr_i    (instr_i),
  .imm_o      (imm_o),
  .jmp_addr_o (jmp_addr_o),
  .reg_wr_o   (reg_wr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .alu_imm_o  (alu_imm_o),
  .branch_o   (branch_o),
  .jump_o     (jump_o),
  .alu_fn_o   (alu_fn_o)
);

// File: tb/test_idec_top.sv
module test_idec_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] instr;
  logic [3:0]  opcode;
  logic [2:0]  rd, rs, rt;
  logic [15:0] imm;
  logic [11:0] jadr;
  logic        reg_wr, mem_rd, mem_wr, alu_imm, branch, jump;
  logic [1:0]  alu_fn;

  int n_vec = 0;
  int n_bad = 0;

  idec_top i_idec_top (
    .instr_i(instr), .opcode_o(opcode), .rd_o(rd), .rs_o(rs), .rt_o(rt),
    .imm_o(imm), .jmp_addr_o(jadr), .reg_wr_o(reg_wr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .alu_imm_o(alu_imm), .branch_o(branch),
    .jump_o(jump), .alu_fn_o(alu_fn)
  );

  // {reg_wr, mem_rd, mem_wr, alu_imm, branch, jump, fn[1:0]}
  function automatic logic [7:0] exp_ctrl(input logic [3:0] op);
    case (op)
      4'h1, 4'h3, 4'h4: return 8'b1000_0000;
      4'h2:             return 8'b1000_0001;
      4'h5:             return 8'b1101_0000;
      4'h6:             return 8'b0011_0000;
      4'h7:             return 8'b0000_1000;
      4'h8:             return 8'b0000_0100;
      default:          return 8'b0000_0000;
    endcase
  endfunction

  function automatic string ctrl_tag(input logic [3:0] op);
    case (op)
      4'h1, 4'h2, 4'h3, 4'h4: return "R5";
      4'h5:                   return "R6";
      4'h6:                   return "R7";
      4'h7, 4'h8:             return "R8";
      default:                return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp,
                     input logic [15:0] w);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, w, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    #2; // R10: settles combinationally, no clock edge needed
    chk("R1", 32'(opcode), 32'(w[15:12]), w);
    chk("R2", 32'({rd, rs, rt}), 32'({w[11:9], w[8:6], w[5:3]}), w);
    chk("R3", 32'(imm), 32'({{7{w[8]}}, w[8:0]}), w);
    chk("R4", 32'(jadr), 32'(w[11:0]), w);
    chk(ctrl_tag(w[15:12]),
        32'({reg_wr, mem_rd, mem_wr, alu_imm, branch, jump, alu_fn}),
        32'(exp_ctrl(w[15:12])), w);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    instr = 16'h0000;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R9 / R10: all-zero word decodes to a bubble
    apply(16'h0000);
    // every opcode with a mixed body
    for (int op = 0; op < 16; op++) apply({op[3:0], 12'hA5C});
    // immediate sign boundaries on load/store (R3, R6, R7)
    apply(16'h50FF);
    apply(16'h5100);
    apply(16'h61FF);
    apply(16'h6000);
    apply(16'hFFFF);
    // reserved bitwise codes with full bodies (R9)
    for (int op = 9; op <= 12; op++) apply({op[3:0], 12'hFFF});
    // jump target extremes (R4, R8)
    apply(16'h8FFF);
    apply(16'h8000);
    void'($urandom(32'h1d2c_0b5e));
    for (int k = 0; k < 2000; k++) apply(16'($urandom()));
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule